// File: doc/BRIEF.md
# Pulse-Swallow Frequency Divider Core

This block is the counting heart of an integer-N frequency synthesizer. A fixed divider takes the crystal clock and produces a one-cycle reference tick. A programmable main divider counts the output pulses of an external dual-modulus prescaler (divide by 32 or 33) and emits a one-cycle divided tick. The prescaler's modulus is steered by a control output from this block. Two counters do the steering. A swallow counter keeps the prescaler at 33 for the first few prescaler periods of each divided cycle. A main counter sets the total number of prescaler periods.

The 14-bit frequency word holds the main count in its upper 9 bits and the swallow count in its lower 5 bits. The overall ratio from the prescaler input to the divided tick is therefore 32 times the main count plus the swallow count, which is numerically the word itself. A ratio of 9186 is written as main 287 and swallow 2.

The two ticks feed a three-state phase/frequency comparator. It produces up and down pulses, and a lock flag built from a run of narrow comparisons drives a lock indicator. A word whose swallow count exceeds its main count is flagged as invalid.

Top module: `freqSynthCore`

## Requirements
- R1: `refTick` is high for exactly one clock in every `REF_DIV` clocks (default 4096, so a 4 MHz crystal gives a 976.5625 Hz comparison rate).
- R2: `freqWord[13:5]` is the main count N and `freqWord[4:0]` the swallow count A. With A ≤ N, consecutive `divTick` pulses are 32·N + A prescaler-input ticks apart. For example, 9186 gives N = 287 and A = 2.
- R3: `modSel` = 1 (divide by 33) for the first A prescaler periods of each divided cycle and 0 (divide by 32) for the remaining N − A periods.
- R4: `wordLoad` latches `freqWord`. The divided cycle in progress finishes with its old counts, and both counters reload from the latched word at the end of every divided cycle.
- R5: `badWord` is 1 exactly when the latched A exceeds the latched N. Such a word runs every prescaler period at 33, which gives a divided period of 33·N.
- R6: `pdUp` rises when a reference tick arrives first and `pdDown` rises when a divided tick arrives first. Either pulse clears when the other tick arrives, and coincident ticks raise neither.
- R7: `lock` sets after `LOCK_COUNT` (default 16) consecutive comparisons whose pulse lasted no more than `LOCK_TOL` clocks. It clears, and the run restarts, as soon as a pulse grows wider than `LOCK_TOL`.
- R8: After reset, all outputs are 0 and the main divider idles until a word is latched.
- R9: A latched main count of 0 stops the divider: no further `divTick` occurs and `modSel` stays at the latched swallow value's effect (0 for a zero word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rstN | input | 1 | Active-low synchronous reset |
| freqWord | input | 14 | Frequency word: main count on top, swallow count below |
| wordLoad | input | 1 | Latch `freqWord` this clock |
| prescPulse | input | 1 | One-clock pulse at the end of each prescaler period |
| modSel | output | 1 | Prescaler modulus: 1 = divide by 33, 0 = divide by 32 |
| refTick | output | 1 | Reference divider tick |
| divTick | output | 1 | Main divider tick |
| pdUp | output | 1 | Comparator up pulse |
| pdDown | output | 1 | Comparator down pulse |
| lock | output | 1 | Loop lock flag |
| badWord | output | 1 | Swallow count exceeds main count |

## Verification
The bench builds the core with `REF_DIV` = 330 and `LOCK_TOL` = 48, keeping the 14-bit word and `LOCK_COUNT` = 16. The short reference lets a valid word (N = 10, A = 10) match the reference exactly, so lock acquisition and loss under words of 352 and 320 fit in a few tens of thousands of clocks. The full word width stays in place, so the 9186 split and the invalid-word periods are measured against a bench model of the 32/33 prescaler clocked once per cycle.

// File: rtl/synthPkg.sv
package synthPkg;

  // Strobes from the divider control to the datapath
  typedef struct packed {
    logic latchWord;
    logic start;
    logic wrap;
    logic step;
    logic stepSwallow;
  } divStrobe_t;

  // Counter status from the datapath back to the control
  typedef struct packed {
    logic mainIdle;
    logic mainLast;
    logic swallowLeft;
  } divStatus_t;

  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_UP   = 2'd1,
    PD_DOWN = 2'd2
  } pdState_t;

endpackage

// File: rtl/synthDivCtrl.sv
module synthDivCtrl
  import synthPkg::*;
(
  input  logic       prescPulse,
  input  logic       wordLoad,
  input  divStatus_t status,
  output divStrobe_t strb
);

  always_comb begin
    strb.latchWord   = wordLoad;
    // R8/R9: an idle main counter reloads from the latched word every clock
    strb.start       = status.mainIdle;
    // R4: the last prescaler period of a cycle ends it and reloads both counters
    strb.wrap        = prescPulse && !status.mainIdle && status.mainLast;
    strb.step        = prescPulse && !status.mainIdle && !status.mainLast;
    // R3: the swallow counter only moves while it still has periods to swallow
    strb.stepSwallow = strb.step && status.swallowLeft;
  end

endmodule

// File: rtl/synthDatapath.sv
module synthDatapath
  import synthPkg::*;
#(
  parameter int REF_DIV = 4096,
  parameter int MAIN_W  = 9,
  parameter int SWAL_W  = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [MAIN_W+SWAL_W-1:0] wordIn,
  input  divStrobe_t               strb,
  output divStatus_t               status,
  output logic                     modSel,
  output logic                     badWord,
  output logic                     refTick,
  output logic                     divTick
);

  localparam int WORD_W = MAIN_W + SWAL_W;
  localparam int REF_W  = $clog2(REF_DIV);

  logic [WORD_W-1:0] wordReg;
  logic [MAIN_W-1:0] wordMain, mainCnt;
  logic [SWAL_W-1:0] wordSwal, swalCnt;
  logic [REF_W-1:0]  refCnt;

  assign wordMain = wordReg[WORD_W-1:SWAL_W];
  assign wordSwal = wordReg[SWAL_W-1:0];

  // R1: fixed reference divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt  <= '0;
      refTick <= 1'b0;
    end else if (refCnt == REF_W'(REF_DIV - 1)) begin
      refCnt  <= '0;
      refTick <= 1'b1;
    end else begin
      refCnt  <= refCnt + 1'b1;
      refTick <= 1'b0;
    end
  end

  // R4: word latch
  always_ff @(posedge clk) begin
    if (!rstN)               wordReg <= '0;
    else if (strb.latchWord) wordReg <= wordIn;
  end

  // R2/R3: main and swallow counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainCnt <= '0;
      swalCnt <= '0;
      divTick <= 1'b0;
    end else begin
      divTick <= strb.wrap;
      if (strb.start || strb.wrap) begin
        mainCnt <= wordMain;
        swalCnt <= wordSwal;
      end else if (strb.step) begin
        mainCnt <= mainCnt - 1'b1;
        if (strb.stepSwallow) swalCnt <= swalCnt - 1'b1;
      end
    end
  end

  always_comb begin
    status.mainIdle    = (mainCnt == '0);
    status.mainLast    = (mainCnt == MAIN_W'(1));
    status.swallowLeft = (swalCnt != '0);
  end

  assign modSel  = (swalCnt != '0);
  // R5: invalid when more periods must be swallowed than the cycle holds
  assign badWord = int'(wordSwal) > int'(wordMain);

  // R1: reference ticks are isolated single-clock pulses
  p_ref_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    refTick |=> !refTick);

  // R4: every divided tick follows a reload from the latched main count
  p_reload_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    divTick |-> (mainCnt == $past(wordMain)));

  // R3: the divide-by-33 request only ends on a swallow step or a reload
  p_mod_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modSel) |-> $past(strb.stepSwallow || strb.wrap || strb.start));

  // R2: between prescaler pulses a running main count holds
  p_main_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.wrap && !status.mainIdle) |=> $stable(mainCnt));

endmodule

// File: rtl/synthPhaseLock.sv
module synthPhaseLock
  import synthPkg::*;
#(
  parameter int LOCK_TOL   = 8,
  parameter int LOCK_COUNT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic refTick,
  input  logic divTick,
  output logic pdUp,
  output logic pdDown,
  output logic lock
);

  localparam int WID_W = $clog2(LOCK_TOL + 2);
  localparam int CNT_W = $clog2(LOCK_COUNT + 1);

  pdState_t         state, stateNext;
  logic             cmpDone, tooWide;
  logic [WID_W-1:0] widthCnt;
  logic [CNT_W-1:0] goodCnt;

  // R6: three-state comparator
  always_comb begin
    stateNext = state;
    cmpDone   = 1'b0;
    unique case (state)
      PD_IDLE: begin
        if (refTick && divTick) cmpDone = 1'b1;
        else if (refTick)       stateNext = PD_UP;
        else if (divTick)       stateNext = PD_DOWN;
      end
      PD_UP: if (divTick) begin
        stateNext = PD_IDLE;
        cmpDone   = 1'b1;
      end
      PD_DOWN: if (refTick) begin
        stateNext = PD_IDLE;
        cmpDone   = 1'b1;
      end
      default: stateNext = PD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= PD_IDLE;
      widthCnt <= '0;
    end else begin
      state <= stateNext;
      if (stateNext == PD_IDLE)             widthCnt <= '0;
      else if (state == PD_IDLE)            widthCnt <= WID_W'(1);
      else if (widthCnt != WID_W'(LOCK_TOL + 1)) widthCnt <= widthCnt + 1'b1;
    end
  end

  assign tooWide = (widthCnt > WID_W'(LOCK_TOL));

  // R7: run of narrow comparisons
  always_ff @(posedge clk) begin
    if (!rstN) begin
      goodCnt <= '0;
      lock    <= 1'b0;
    end else if (tooWide) begin
      goodCnt <= '0;
      lock    <= 1'b0;
    end else if (cmpDone) begin
      if (goodCnt == CNT_W'(LOCK_COUNT - 1)) lock    <= 1'b1;
      else                                   goodCnt <= goodCnt + 1'b1;
    end
  end

  assign pdUp   = (state == PD_UP);
  assign pdDown = (state == PD_DOWN);

  p_up_from_ref_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdUp) |-> $past(refTick));

  p_down_from_div_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdDown) |-> $past(divTick));

  p_wide_unlocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    tooWide |=> !lock);

  p_lock_on_compare_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lock) |-> $past(cmpDone));

endmodule

// File: rtl/freqSynthCore.sv
module freqSynthCore
  import synthPkg::*;
#(
  parameter int REF_DIV    = 4096,
  parameter int MAIN_W     = 9,
  parameter int SWAL_W     = 5,
  parameter int LOCK_TOL   = 8,
  parameter int LOCK_COUNT = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [MAIN_W+SWAL_W-1:0] freqWord,
  input  logic                     wordLoad,
  input  logic                     prescPulse,
  output logic                     modSel,
  output logic                     refTick,
  output logic                     divTick,
  output logic                     pdUp,
  output logic                     pdDown,
  output logic                     lock,
  output logic                     badWord
);

  divStrobe_t strb;
  divStatus_t status;

  synthDivCtrl uCtrl (
    .prescPulse (prescPulse),
    .wordLoad   (wordLoad),
    .status     (status),
    .strb       (strb)
  );

  synthDatapath #(
    .REF_DIV (REF_DIV),
    .MAIN_W  (MAIN_W),
    .SWAL_W  (SWAL_W)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .wordIn  (freqWord),
    .strb    (strb),
    .status  (status),
    .modSel  (modSel),
    .badWord (badWord),
    .refTick (refTick),
    .divTick (divTick)
  );

  synthPhaseLock #(
    .LOCK_TOL   (LOCK_TOL),
    .LOCK_COUNT (LOCK_COUNT)
  ) uPd (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .divTick (divTick),
    .pdUp    (pdUp),
    .pdDown  (pdDown),
    .lock    (lock)
  );

endmodule

// File: tb/freqSynthCore_test.sv
`timescale 1ns/1ps
module freqSynthCore_test;

  localparam int REF_DIV = 330;
  localparam int NVEC    = 7;
  // word, expected divided period, expected divide-by-33 periods, expected badWord
  localparam int VEC [NVEC][4] = '{
    '{9186, 9186,  2, 0},
    '{ 330,  330, 10, 0},
    '{  32,   32,  0, 0},
    '{  99,   99,  3, 0},
    '{1311, 1311, 31, 0},
    '{  63,   33,  1, 1},
    '{  69,   66,  2, 1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] freqWord = '0;
  logic        wordLoad = 1'b0;
  logic        prescPulse = 1'b0;
  logic        modSel, refTick, divTick, pdUp, pdDown, lock, badWord;

  int  cyc = 0;
  int  cnt33 = 0;
  int  total = 0;
  int  fails = 0;
  bit  sawUp = 0;
  bit  sawDown = 0;
  bit  done = 0;

  freqSynthCore #(.REF_DIV(REF_DIV), .LOCK_TOL(48)) uut (
    .clk(clk), .rstN(rstN), .freqWord(freqWord), .wordLoad(wordLoad),
    .prescPulse(prescPulse), .modSel(modSel), .refTick(refTick),
    .divTick(divTick), .pdUp(pdUp), .pdDown(pdDown), .lock(lock),
    .badWord(badWord)
  );

  always #5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // Dual-modulus prescaler model: one input tick per clock
  initial begin
    int c = 0;
    int m = 32;
    forever begin
      @(negedge clk);
      prescPulse = 1'b0;
      if (!rstN) c = 0;
      else begin
        if (c == 0) m = modSel ? 33 : 32;
        c++;
        if (c == m) begin
          prescPulse = 1'b1;
          c = 0;
          if (m == 33) cnt33++;
        end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (pdUp)   sawUp = 1;
    if (pdDown) sawDown = 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic loadWord(input int w);
    @(negedge clk);
    freqWord = 14'(w);
    wordLoad = 1'b1;
    @(negedge clk);
    wordLoad = 1'b0;
  endtask

  task automatic waitDiv(output int t, output int c33);
    do @(negedge clk); while (!divTick);
    t = cyc;
    c33 = cnt33;
  endtask

  task automatic waitRef(output int t);
    do @(negedge clk); while (!refTick);
    t = cyc;
  endtask

  initial begin
    int r1, r2, r3, t0, t1, t2, c0, c1, c2, n;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 pdUp",    int'(pdUp), 0);
    check("R8 pdDown",  int'(pdDown), 0);
    check("R8 lock",    int'(lock), 0);
    check("R8 modSel",  int'(modSel), 0);
    check("R8 divTick", int'(divTick), 0);
    check("R8 badWord", int'(badWord), 0);

    // R1 reference period
    waitRef(r1); waitRef(r2); waitRef(r3);
    check("R1 ref period a", r2 - r1, REF_DIV);
    check("R1 ref period b", r3 - r2, REF_DIV);

    // R7 acquisition with a matching word (N=10, A=10)
    loadWord(330);
    for (int i = 0; i < 22; i++) waitRef(r1);
    check("R7 lock acquired", int'(lock), 1);
    for (int i = 0; i < 5; i++) waitRef(r1);
    check("R7 lock held", int'(lock), 1);

    // R6/R7 slow divided clock: up pulses, lock lost
    sawUp = 0;
    loadWord(352);
    for (int i = 0; i < 40; i++) waitRef(r1);
    check("R7 lock lost slow", int'(lock), 0);
    check("R6 up seen", int'(sawUp), 1);

    // R6/R7 fast divided clock: down pulses
    sawDown = 0;
    loadWord(320);
    for (int i = 0; i < 40; i++) waitRef(r1);
    check("R7 lock lost fast", int'(lock), 0);
    check("R6 down seen", int'(sawDown), 1);

    // R2/R3/R5 vector table
    for (int i = 0; i < NVEC; i++) begin
      loadWord(VEC[i][0]);
      check($sformatf("R5 badWord word %0d", VEC[i][0]), int'(badWord), VEC[i][3]);
      waitDiv(t0, c0);
      waitDiv(t1, c1);
      waitDiv(t2, c2);
      check($sformatf("R2 period word %0d", VEC[i][0]), t2 - t1, VEC[i][1]);
      check($sformatf("R3 swallow periods word %0d", VEC[i][0]), c2 - c1, VEC[i][2]);
    end

    // R4 a new word waits for the running cycle to finish
    loadWord(330);
    waitDiv(t0, c0);
    waitDiv(t0, c0);
    repeat (100) @(negedge clk);
    loadWord(99);
    waitDiv(t1, c1);
    check("R4 old cycle kept", t1 - t0, 330);
    waitDiv(t2, c2);
    check("R4 new word used", t2 - t1, 99);

    // R9 zero main count stops the divider
    loadWord(0);
    waitDiv(t0, c0);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (divTick) n++;
    end
    check("R9 no divTick", n, 0);
    check("R9 modSel low", int'(modSel), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

endmodule